// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block sits between a core's store path and an external memory bus. Each store of one, two or four bytes is placed into one of eight entries. Each entry covers an aligned 16-byte region and keeps a per-byte enable mask. A store whose region matches any held entry is merged into that entry, provided the entry is not the one currently offered on the bus. Otherwise the store takes a free entry. Entries leave in the order they were allocated, one for each bus handshake.

Both data interfaces are valid/ready streams. A store is accepted in a cycle where `st_valid` and `st_ready` are both high. `st_ready` is combinational from the buffer state and `st_addr`, so the core keeps a store's fields stable until it is accepted. The bus side offers the oldest entry whenever the buffer is not empty. While `bus_valid` is high and `bus_ready` is low, the offered address, data and byte enables do not change. An entry is released on the edge where `bus_valid` and `bus_ready` are both high.

Top module: `store_merge_buffer`

## Requirements
- R1: While reset is asserted and immediately after it, `st_ready` is 1 and `bus_valid` is 0.
- R2: Bus byte k is `bus_data[8k+7:8k]` and is enabled by `bus_be[k]`. The byte offset is `st_addr[3:0]`. The size codes are: 0 = byte, 1 = halfword, 2 = word, 3 = also a word. A byte store writes `st_data[7:0]` to byte `st_addr[3:0]`. A halfword store writes `st_data[15:0]`, low byte first, starting at byte `2*st_addr[3:1]`. A word store writes `st_data[31:0]` starting at byte `4*st_addr[3:2]`. Address bits below the access size are ignored. Bytes outside the mask read as zero.
- R3: A store to the 16-byte region of a held entry that is not being offered on the bus merges into that entry. The entry's enable mask becomes the OR of all merged stores, and a later store to a byte overwrites that byte.
- R4: A store to the region of the entry currently offered on the bus allocates a new entry. While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_data` and `bus_be` stay unchanged.
- R5: Entries drain in allocation order, one per handshake. `bus_addr` carries the region base with bits [3:0] equal to zero.
- R6: When all eight entries are held and no merge is possible, `st_ready` is 0. A store that can merge into a non-offered entry is still accepted.
- R7: An entry that drains frees its slot for the next cycle, not for the cycle of the handshake.
- R8: `bus_valid` is high exactly while at least one entry is held, and it stays high until the handshake.
- R9: A store acceptance and a drain handshake in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 32 | Store data, right-justified |
| bus_valid | output | 1 | An entry is offered on the bus |
| bus_ready | input | 1 | Bus accepts the offered entry |
| bus_addr | output | ADDR_W | 16-byte aligned region address |
| bus_data | output | 8*LINE_BYTES | Entry data |
| bus_be | output | LINE_BYTES | Per-byte enables |

## Verification
Byte placement is swept over every size code and every one of the sixteen offsets, each store draining alone. This separates errors in lane selection, in ignoring the low address bits, and in zeroing unused bytes. A mixed sequence of several stores into one region, one of which overwrites a byte, shows the difference between OR-merging and replacement. A repeat store to the region being offered shows that the offered entry is not modified. A full buffer is probed with a new region, a mergeable region and the offered region. This separates a stall caused by fullness from a stall caused by the merge rule, and the probe is repeated across a drain handshake to fix the cycle in which a slot is freed. A store and a drain in the same cycle confirm that both take effect.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD3 = 2'd3
  } st_size_e;
endpackage

// File: rtl/smb_lane_gen.sv
module smb_lane_gen
  import smb_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  localparam int OFS_W = $clog2(LINE_BYTES),
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic [1:0]            size_i,
  input  logic [OFS_W-1:0]      offset_i,
  input  logic [31:0]           data_i,
  output logic [LINE_BYTES-1:0] mask_o,
  output logic [LINE_W-1:0]     lane_o
);
  always_comb begin
    int base;
    int nbytes;
    case (st_size_e'(size_i))
      SZ_BYTE: begin base = int'(offset_i);        nbytes = 1; end
      SZ_HALF: begin base = int'(offset_i) & ~1;   nbytes = 2; end
      default: begin base = int'(offset_i) & ~3;   nbytes = 4; end
    endcase
    for (int b = 0; b < LINE_BYTES; b++) begin
      int rel;
      logic hit;
      rel = b - base;
      hit = (rel >= 0) && (rel < nbytes);
      mask_o[b] = hit;
      lane_o[b*8 +: 8] = hit ? 8'(data_i >> (8 * rel)) : 8'h00;
    end
  end
endmodule

// File: rtl/smb_entry.sv
module smb_entry #(
  parameter int TAG_W = 28,
  parameter int LINE_BYTES = 16,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_i,
  input  logic                  merge_i,
  input  logic                  clear_i,
  input  logic [TAG_W-1:0]      tag_i,
  input  logic [LINE_BYTES-1:0] wmask_i,
  input  logic [LINE_W-1:0]     wdata_i,
  output logic                  valid_o,
  output logic [TAG_W-1:0]      tag_o,
  output logic [LINE_BYTES-1:0] mask_o,
  output logic [LINE_W-1:0]     data_o
);
  logic                  valid_q;
  logic [TAG_W-1:0]      tag_q;
  logic [LINE_BYTES-1:0] mask_q;
  logic [LINE_W-1:0]     data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      mask_q  <= '0;
      data_q  <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      tag_q   <= tag_i;
      mask_q  <= wmask_i;
      data_q  <= wdata_i;
    end else if (merge_i) begin
      mask_q <= mask_q | wmask_i;
      for (int b = 0; b < LINE_BYTES; b++)
        if (wmask_i[b]) data_q[b*8 +: 8] <= wdata_i[b*8 +: 8];
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign mask_o  = mask_q;
  assign data_o  = data_q;

  assert_alloc_into_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !valid_q);
  assert_merge_into_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> (valid_q && !clear_i));
  assert_clear_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !valid_q);
endmodule

// File: rtl/smb_order_q.sv
module smb_order_q #(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT),
  localparam int CNT_W = $clog2(NUM_ENT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_idx_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_idx_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [IDX_W-1:0] slot_q [NUM_ENT];
  logic [IDX_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_ENT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= step(wr_q);
      if (pop_i)  rd_q <= step(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) slot_q[wr_q] <= push_idx_i;
  end

  assign head_idx_o = slot_q[rd_q];
  assign empty_o    = (cnt_q == '0);
  assign count_o    = cnt_q;

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CNT_W'(NUM_ENT)));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer #(
  parameter int ADDR_W = 32,
  parameter int NUM_ENT = 8,
  parameter int LINE_BYTES = 16,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [1:0]            st_size,
  input  logic [31:0]           st_data,
  output logic                  bus_valid,
  input  logic                  bus_ready,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [LINE_W-1:0]     bus_data,
  output logic [LINE_BYTES-1:0] bus_be
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int IDX_W = $clog2(NUM_ENT);
  localparam int CNT_W = $clog2(NUM_ENT + 1);

  logic [TAG_W-1:0]      st_tag;
  logic [LINE_BYTES-1:0] st_mask;
  logic [LINE_W-1:0]     st_lanes;

  logic [NUM_ENT-1:0]    valid_vec, match_vec, alloc_vec, merge_vec, clear_vec;
  logic [TAG_W-1:0]      ent_tag  [NUM_ENT];
  logic [LINE_BYTES-1:0] ent_mask [NUM_ENT];
  logic [LINE_W-1:0]     ent_data [NUM_ENT];

  logic [IDX_W-1:0] head_idx, free_idx;
  logic [CNT_W-1:0] q_count;
  logic             q_empty, any_free, any_match, accept, drain, push;

  assign st_tag = st_addr[ADDR_W-1:OFS_W];

  smb_lane_gen #(.LINE_BYTES(LINE_BYTES)) u_lanes (
    .size_i  (st_size),
    .offset_i(st_addr[OFS_W-1:0]),
    .data_i  (st_data),
    .mask_o  (st_mask),
    .lane_o  (st_lanes)
  );

  // Merge candidates: held entries of the same region, except the one on the bus
  always_comb begin
    for (int i = 0; i < NUM_ENT; i++)
      match_vec[i] = valid_vec[i] && (ent_tag[i] == st_tag)
                     && !(bus_valid && (head_idx == IDX_W'(i)));
  end

  // Lowest-numbered free slot
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign any_match = |match_vec;
  assign st_ready  = any_match || any_free;
  assign accept    = st_valid && st_ready;
  assign push      = accept && !any_match;
  assign bus_valid = !q_empty;
  assign drain     = bus_valid && bus_ready;

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
      assign alloc_vec[g] = push && (free_idx == IDX_W'(g));
      assign merge_vec[g] = accept && match_vec[g];
      assign clear_vec[g] = drain && (head_idx == IDX_W'(g));

      smb_entry #(.TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)) u_entry (
        .clk    (clk),
        .rst_n  (rst_n),
        .alloc_i(alloc_vec[g]),
        .merge_i(merge_vec[g]),
        .clear_i(clear_vec[g]),
        .tag_i  (st_tag),
        .wmask_i(st_mask),
        .wdata_i(st_lanes),
        .valid_o(valid_vec[g]),
        .tag_o  (ent_tag[g]),
        .mask_o (ent_mask[g]),
        .data_o (ent_data[g])
      );
    end
  endgenerate

  smb_order_q #(.NUM_ENT(NUM_ENT)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push),
    .push_idx_i(free_idx),
    .pop_i     (drain),
    .head_idx_o(head_idx),
    .empty_o   (q_empty),
    .count_o   (q_count)
  );

  assign bus_addr = {ent_tag[head_idx], {OFS_W{1'b0}}};
  assign bus_data = ent_data[head_idx];
  assign bus_be   = ent_mask[head_idx];

  assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                   && $stable(bus_data) && $stable(bus_be)));
  assert_order_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_vec) == int'(q_count));
  assert_enables_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (|bus_be));
  assert_stall_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> ($countones(valid_vec) == NUM_ENT));
  assert_drain_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(valid_vec) == NUM_ENT) && drain) |=> ($countones(valid_vec) == NUM_ENT - 1));
  assert_head_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> valid_vec[head_idx]);
endmodule

// File: tb/store_merge_buffer_bench.sv
module store_merge_buffer_bench;
  localparam int AW = 32;
  localparam int LB = 16;
  localparam int LW = LB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [1:0]    st_size = '0;
  logic [31:0]   st_data = '0;
  logic          bus_valid;
  logic          bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [LW-1:0] bus_data;
  logic [LB-1:0] bus_be;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  store_merge_buffer u_store_merge_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_size(st_size), .st_data(st_data),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_be(bus_be)
  );

  task automatic cmp(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void lanes(input logic [1:0] sz, input logic [AW-1:0] a,
                                input logic [31:0] d,
                                output logic [LB-1:0] be, output logic [LW-1:0] dat);
    int o;
    case (sz)
      2'd0: begin o = int'(a[3:0]);        be = LB'(16'h0001) << o; dat = LW'(d[7:0])  << (8 * o); end
      2'd1: begin o = int'(a[3:0]) & 14;   be = LB'(16'h0003) << o; dat = LW'(d[15:0]) << (8 * o); end
      default: begin o = int'(a[3:0]) & 12; be = LB'(16'h000F) << o; dat = LW'(d)      << (8 * o); end
    endcase
  endfunction

  function automatic logic [LW-1:0] apply(input logic [LW-1:0] old, input logic [LB-1:0] be,
                                          input logic [LW-1:0] dat);
    logic [LW-1:0] r;
    r = old;
    for (int k = 0; k < LB; k++) if (be[k]) r[k*8 +: 8] = dat[k*8 +: 8];
    return r;
  endfunction

  task automatic store(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_size = sz; st_data = d;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 st_valid = 1'b0;
  endtask

  task automatic drain_expect(input string req, input logic [AW-1:0] a,
                              input logic [LW-1:0] dat, input logic [LB-1:0] be);
    @(negedge clk);
    cmp({req, " bus_valid"}, LW'(bus_valid), LW'(1));
    cmp({req, " bus_addr"}, LW'(bus_addr), LW'(a));
    cmp({req, " bus_data"}, bus_data, dat);
    cmp({req, " bus_be"}, LW'(bus_be), LW'(be));
    bus_ready = 1'b1;
    @(posedge clk);
    #1 bus_ready = 1'b0;
  endtask

  initial begin
    logic [LB-1:0] be, be2;
    logic [LW-1:0] dat, dat2, y_dat, x_dat;
    logic [LB-1:0] y_be, x_be;
    logic [AW-1:0] a;
    logic [31:0]   d;

    // R1: reset state
    repeat (2) @(negedge clk);
    cmp("R1 st_ready in reset", LW'(st_ready), LW'(1));
    cmp("R1 bus_valid in reset", LW'(bus_valid), LW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 st_ready after reset", LW'(st_ready), LW'(1));
    cmp("R1 bus_valid after reset", LW'(bus_valid), LW'(0));

    // R2: every size code at every offset, each drained alone
    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 16; off++) begin
        a = 32'h0000_1000 + AW'((sz * 16 + off) * 16 + off);
        d = 32'hA1B2_C3D4 ^ (32'h0101_0101 * (sz * 16 + off));
        store(a, 2'(sz), d);
        lanes(2'(sz), a, d, be, dat);
        drain_expect("R2", {a[AW-1:4], 4'h0}, dat, be);
      end
    end
    @(negedge clk);
    cmp("R8 bus_valid idle after sweep", LW'(bus_valid), LW'(0));

    // R3/R4: merging, overwrite, and the offered entry left alone
    store(32'h2000_0040, 2'd2, 32'h1122_3344);
    lanes(2'd2, 32'h2000_0040, 32'h1122_3344, y_be, y_dat);
    x_be = '0; x_dat = '0;
    store(32'h3000_0080, 2'd0, 32'h0000_00AA);
    lanes(2'd0, 32'h3000_0080, 32'h0000_00AA, be, dat); x_be |= be; x_dat = apply(x_dat, be, dat);
    store(32'h3000_0082, 2'd1, 32'h0000_BBCC);
    lanes(2'd1, 32'h3000_0082, 32'h0000_BBCC, be, dat); x_be |= be; x_dat = apply(x_dat, be, dat);
    store(32'h3000_0088, 2'd2, 32'hDDEE_FF00);
    lanes(2'd2, 32'h3000_0088, 32'hDDEE_FF00, be, dat); x_be |= be; x_dat = apply(x_dat, be, dat);
    store(32'h3000_0089, 2'd0, 32'h0000_0077);
    lanes(2'd0, 32'h3000_0089, 32'h0000_0077, be, dat); x_be |= be; x_dat = apply(x_dat, be, dat);
    store(32'h2000_0044, 2'd2, 32'h5566_7788);
    lanes(2'd2, 32'h2000_0044, 32'h5566_7788, be2, dat2);
    @(negedge clk);
    cmp("R8 bus_valid held while waiting", LW'(bus_valid), LW'(1));
    cmp("R4 offered data unchanged", bus_data, y_dat);
    cmp("R4 offered enables unchanged", LW'(bus_be), LW'(y_be));
    drain_expect("R5 first allocated", 32'h2000_0040, y_dat, y_be);
    drain_expect("R3 merged entry", 32'h3000_0080, x_dat, x_be);
    drain_expect("R4 separate entry", 32'h2000_0040, dat2, be2);
    @(negedge clk);
    cmp("R8 bus_valid idle after merge test", LW'(bus_valid), LW'(0));

    // R6/R7: full buffer
    for (int k = 0; k < 8; k++)
      store(32'h4000_0000 + AW'(k * 16), 2'd2, 32'(k + 1));
    @(negedge clk);
    st_valid = 1'b1; st_size = 2'd2; st_data = 32'hCAFE_F00D;
    st_addr = 32'h5000_0000; #1;
    cmp("R6 full new region stalls", LW'(st_ready), LW'(0));
    st_addr = 32'h4000_0020; #1;
    cmp("R6 full mergeable region ready", LW'(st_ready), LW'(1));
    st_addr = 32'h4000_0000; #1;
    cmp("R6 full offered region stalls", LW'(st_ready), LW'(0));
    st_addr = 32'h5000_0000;
    bus_ready = 1'b1; #1;
    cmp("R7 no slot during handshake", LW'(st_ready), LW'(0));
    cmp("R5 head is oldest", LW'(bus_addr), LW'(32'h4000_0000));
    @(posedge clk);
    #1 bus_ready = 1'b0;
    cmp("R7 slot free next cycle", LW'(st_ready), LW'(1));
    @(posedge clk);
    #1 st_valid = 1'b0;
    for (int k = 1; k < 8; k++) begin
      lanes(2'd2, 32'h0, 32'(k + 1), be, dat);
      drain_expect("R5 order", 32'h4000_0000 + AW'(k * 16), dat, be);
    end
    lanes(2'd2, 32'h0, 32'hCAFE_F00D, be, dat);
    drain_expect("R5 order refilled slot", 32'h5000_0000, dat, be);

    // R9: store and drain in one cycle
    store(32'h6000_0010, 2'd0, 32'h0000_005A);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h6000_0020; st_size = 2'd1; st_data = 32'h0000_1234;
    bus_ready = 1'b1; #1;
    cmp("R9 store ready during drain", LW'(st_ready), LW'(1));
    cmp("R9 offered entry", LW'(bus_addr), LW'(32'h6000_0010));
    @(posedge clk);
    #1 begin st_valid = 1'b0; bus_ready = 1'b0; end
    lanes(2'd1, 32'h6000_0020, 32'h0000_1234, be, dat);
    drain_expect("R9 both took effect", 32'h6000_0020, dat, be);
    @(negedge clk);
    cmp("R8 bus_valid idle at end", LW'(bus_valid), LW'(0));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1-through-end: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule